// File: doc/BRIEF.md
# Serial Flash Boot Loader

This block is the master side of a single-line serial flash link, used to fetch a configuration image right after reset. When reset is released it looks once at a small set of boot-mode straps. If the straps select serial boot, it waits a short guard time with the flash deselected. It then selects the flash and sends a read command with start address zero. After that it clocks in a fixed number of image bytes and hands each one to the fabric with a single-cycle strobe.

Once the final byte has arrived, it finishes the last clock pulse, deselects the flash and raises a done flag. That flag stays high until the next reset. If the straps select any other boot mode, the block parks. The select stays high, the clock stays low and done never rises. Straps are read only once, so later changes on those pins are ignored.

The serial clock period is derived from the system clock rate and a per-device ceiling on the flash clock. Smaller parts are run at 20 MHz at most and larger ones at 40 MHz.

Top module: `sfboot_loader`

## Requirements
- R1: When the boot straps sampled in the first cycle after reset differ from the serial-boot code 2'b10, the block never lowers the select, never pulses the serial clock, never strobes a byte and never raises done.
- R2: In serial boot, the select stays high for at least CSH_CYC system clocks after reset. It then falls exactly once and stays low for the whole transfer.
- R3: The first 32 bits driven to the flash, as seen at rising serial clock edges, are the read opcode 0x03 followed by the 24-bit address 0x000000, each sent most significant bit first.
- R4: The outbound data line changes only while the serial clock is low, so it is stable across every rising edge and every high phase.
- R5: Inbound data is sampled on rising serial clock edges after the 32 header bits. It is packed most significant bit first into bytes, and each byte is presented on cfg_byte with a cfg_valid pulse one system clock long. Exactly NBYTES bytes are delivered.
- R6: Exactly 32 + 8*NBYTES rising serial clock edges occur per boot. The serial clock is low whenever the select is high.
- R7: Every high phase and every low phase of the serial clock, including the setup gap after the select falls, lasts exactly H system clocks. H is the smallest integer with SYS_MHZ <= 2*H*SCK_MAX_MHZ, which keeps the flash clock at or below its ceiling.
- R8: After the final falling clock edge the select returns high and done rises in the same cycle. Both hold until reset, with no further clock pulses.
- R9: Strap changes after the sampling cycle have no effect: a running transfer completes unchanged, and a parked block stays parked.
- R10: The last byte strobe comes before done rises, and no byte strobe occurs while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | MODE_W | Boot-mode straps, sampled once after reset |
| flash_cs_n | output | 1 | Flash select, active low |
| flash_sck | output | 1 | Serial clock to the flash, idles low |
| flash_mosi | output | 1 | Command and address bits to the flash |
| flash_miso | input | 1 | Image data from the flash |
| cfg_byte | output | 8 | Most recently assembled image byte |
| cfg_valid | output | 1 | One-cycle strobe marking a new cfg_byte |
| boot_done | output | 1 | Image fully read and flash released |

## Verification
The rising serial clock edge that captures the last bit of the final byte also marks the end of the stream. Byte completion and end-of-stream detection therefore fall in the same cycle. This is provoked on two instances, one with a three-cycle half period and sixteen bytes and one with a two-cycle half period and five bytes, each fed by a behavioural flash that streams a seeded byte pattern. It is judged at the ports: the final byte must carry the expected value, its strobe must come strictly before done, the clock edge count must stop exactly at the header plus the data bits, and no strobe may appear once done is high.

// File: rtl/sfboot_pkg.sv
package sfboot_pkg;

  localparam logic [7:0]  READ_OPCODE = 8'h03;
  localparam logic [23:0] BOOT_ADDR   = 24'h000000;
  localparam int unsigned CMD_BITS    = 32;

  typedef enum logic [2:0] {
    ST_SAMPLE,
    ST_HALT,
    ST_GUARD,
    ST_XFER,
    ST_DONE
  } boot_state_t;

  // System clocks per serial clock phase: smallest value that keeps the
  // serial clock at or below the device ceiling.
  function automatic int unsigned sck_half_cycles(input int unsigned sys_mhz,
                                                  input int unsigned max_mhz);
    int unsigned per;
    int unsigned h;
    per = 2 * max_mhz;
    h   = (sys_mhz + per - 1) / per;
    return (h == 0) ? 1 : h;
  endfunction

  function automatic logic [CMD_BITS-1:0] read_header(input logic [7:0]  op,
                                                      input logic [23:0] addr);
    return {op, addr};
  endfunction

endpackage

// File: rtl/sfboot_sckgen.sv
module sfboot_sckgen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic fall
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == TOP);
  assign rise = wrap && !sck;
  assign fall = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (cnt == TOP) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: the serial clock only toggles once a full phase has elapsed
  a_r7_no_early_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(wrap)) |-> $stable(sck));

endmodule

// File: rtl/sfboot_txshift.sv
module sfboot_txshift #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_o
);

  logic [W-1:0] sr;

  assign bit_o = sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (load) begin
      sr <= load_val;
    end else if (shift) begin
      sr <= {sr[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/sfboot_rxbytes.sv
module sfboot_rxbytes #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          bit_in,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);

  localparam int IW = $clog2(DW);

  logic [DW-2:0] sr;
  logic [IW-1:0] idx;
  logic [DW-1:0] next_word;
  logic          word_full;

  assign next_word = {sr, bit_in};
  assign word_full = sample && (idx == IW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      idx     <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (sample) begin
        sr <= next_word[DW-2:0];
        if (word_full) begin
          data_o  <= next_word;
          valid_o <= 1'b1;
          idx     <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R5: each byte strobe lasts a single system clock
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

endmodule

// File: rtl/sfboot_loader.sv
module sfboot_loader
  import sfboot_pkg::*;
#(
  parameter int unsigned SYS_MHZ     = 100,
  parameter int unsigned SCK_MAX_MHZ = 20,
  parameter int unsigned NBYTES      = 16,
  parameter int unsigned CSH_CYC     = 8,
  parameter int unsigned MODE_W      = 2,
  parameter logic [MODE_W-1:0] MODE_SERIAL = MODE_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              flash_cs_n,
  output logic              flash_sck,
  output logic              flash_mosi,
  input  logic              flash_miso,
  output logic [7:0]        cfg_byte,
  output logic              cfg_valid,
  output logic              boot_done
);

  localparam int unsigned HALF       = sck_half_cycles(SYS_MHZ, SCK_MAX_MHZ);
  localparam int unsigned TOTAL_BITS = CMD_BITS + NBYTES * 8;
  localparam int BCW = $clog2(TOTAL_BITS + 1);
  localparam int GCW = (CSH_CYC > 1) ? $clog2(CSH_CYC) : 1;

  boot_state_t    state;
  logic [GCW-1:0] gcnt;
  logic [BCW-1:0] bitcnt;
  logic           last_seen;
  logic           cs_n_q;
  logic           done_q;

  // Named internal events
  logic mode_is_serial;
  logic guard_end;
  logic running;
  logic sck_rise;
  logic sck_fall;
  logic in_data;
  logic bit_is_last;
  logic halted;

  assign mode_is_serial = (mode_sel == MODE_SERIAL);
  assign guard_end      = (state == ST_GUARD) && (gcnt == GCW'(CSH_CYC - 1));
  assign running        = (state == ST_XFER);
  assign in_data        = (bitcnt >= BCW'(CMD_BITS));
  assign bit_is_last    = (bitcnt == BCW'(TOTAL_BITS - 1));
  assign halted         = (state == ST_HALT);

  sfboot_sckgen #(.HALF(HALF)) u_sckgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .sck   (flash_sck),
    .rise  (sck_rise),
    .fall  (sck_fall)
  );

  sfboot_txshift #(.W(CMD_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (guard_end),
    .load_val (read_header(READ_OPCODE, BOOT_ADDR)),
    .shift    (running && sck_fall),
    .bit_o    (flash_mosi)
  );

  sfboot_rxbytes #(.DW(8)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (running && sck_rise && in_data),
    .bit_in  (flash_miso),
    .data_o  (cfg_byte),
    .valid_o (cfg_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SAMPLE;
      gcnt      <= '0;
      bitcnt    <= '0;
      last_seen <= 1'b0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      case (state)
        ST_SAMPLE: state <= mode_is_serial ? ST_GUARD : ST_HALT;
        ST_GUARD: begin
          if (guard_end) begin
            state  <= ST_XFER;
            cs_n_q <= 1'b0;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (sck_rise) begin
            bitcnt <= bitcnt + 1'b1;
            if (bit_is_last) last_seen <= 1'b1;
          end
          if (sck_fall && last_seen) begin
            state  <= ST_DONE;
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign flash_cs_n = cs_n_q;
  assign boot_done  = done_q;

  // R8: done implies the flash is deselected, and done is sticky
  a_r8_done_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> flash_cs_n);
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  // R6: clock idles low while deselected; bit count never overruns
  a_r6_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= BCW'(TOTAL_BITS));
  // R4: outbound line holds while the clock is high
  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_sck && $past(flash_sck)) |-> $stable(flash_mosi));
  // R10: no byte strobe once done
  a_r10_no_byte_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !cfg_valid);
  // R1: parked block stays quiet
  a_r1_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (flash_cs_n && !boot_done && !flash_sck));

endmodule

// File: tb/sfboot_loader_tb.sv
module tb_flash_model #(
  parameter int NB = 4
) (
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        mosi,
  input  logic [7:0]  seed,
  output logic        miso,
  output logic [31:0] cmd,
  output int          rises
);
  function automatic logic [7:0] pbyte(input logic [7:0] s, input int i);
    return s ^ 8'((i * 29) & 255);
  endfunction

  always @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      rises <= 0;
      cmd   <= '0;
    end else if (!cs_n) begin
      if (rises < 32) cmd <= {cmd[30:0], mosi};
      rises <= rises + 1;
    end
  end

  always @(negedge sck or negedge rst_n) begin
    if (!rst_n) begin
      miso <= 1'b0;
    end else if (!cs_n && rises >= 32 && (rises - 32) < NB * 8) begin
      miso <= pbyte(seed, (rises - 32) / 8)[7 - ((rises - 32) % 8)];
    end
  end
endmodule

module tb_mon #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  input  logic          valid,
  input  logic [7:0]    data,
  input  logic          done,
  output int            n_valid,
  output logic [NB*8-1:0] bytes_flat,
  output int            sck_rises,
  output int            hi_min,
  output int            hi_max,
  output int            lo_min,
  output int            lo_max,
  output int            cs_falls,
  output int            cs_pre,
  output int            mosi_bad,
  output int            idle_bad,
  output int            valid_in_done,
  output int            last_valid_cyc,
  output int            first_done_cyc
);
  logic p_sck, p_cs, p_mosi;
  int   run, cyc;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_valid = 0; bytes_flat = '0; sck_rises = 0; cs_falls = 0; cs_pre = 0;
      hi_min = 999999; hi_max = 0; lo_min = 999999; lo_max = 0;
      mosi_bad = 0; idle_bad = 0; valid_in_done = 0;
      last_valid_cyc = -1; first_done_cyc = -1;
      p_sck = 1'b0; p_cs = 1'b1; p_mosi = 1'b0; run = 0; cyc = 0;
    end else begin
      cyc++;
      if (valid) begin
        if (n_valid < NB) bytes_flat[n_valid*8 +: 8] = data;
        n_valid++;
        last_valid_cyc = cyc;
        if (done) valid_in_done++;
      end
      if (done && first_done_cyc < 0) first_done_cyc = cyc;
      if (cs_n && sck) idle_bad++;
      if (cs_falls == 0 && cs_n) cs_pre++;
      if (sck && !p_sck) sck_rises++;
      if (!cs_n && p_cs) begin
        cs_falls++;
        run = 1;
      end else if (!cs_n) begin
        if (sck != p_sck) begin
          if (p_sck) begin
            if (run < hi_min) hi_min = run;
            if (run > hi_max) hi_max = run;
          end else begin
            if (run < lo_min) lo_min = run;
            if (run > lo_max) lo_max = run;
          end
          run = 1;
        end else begin
          run++;
        end
      end
      if (!cs_n && sck && p_sck && mosi != p_mosi) mosi_bad++;
      p_sck = sck; p_cs = cs_n; p_mosi = mosi;
    end
  end
endmodule

module sfboot_loader_tb;
  localparam int SYS   = 100;
  localparam int NB_A  = 16;
  localparam int NB_B  = 5;
  localparam int CSH_A = 8;
  localparam int CSH_B = 3;
  localparam int MAX_A = 20;
  localparam int MAX_B = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] seed_a = 8'h00;
  logic [7:0] seed_b = 8'h00;

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // instance A
  logic a_cs, a_sck, a_mosi, a_miso, a_valid, a_done;
  logic [7:0] a_byte;
  logic [31:0] a_cmd;
  int a_frises;
  int a_nv, a_rises, a_himin, a_himax, a_lomin, a_lomax, a_csf, a_cspre;
  int a_mbad, a_ibad, a_vdone, a_lastv, a_firstd;
  logic [NB_A*8-1:0] a_bytes;

  // instance B
  logic b_cs, b_sck, b_mosi, b_miso, b_valid, b_done;
  logic [7:0] b_byte;
  logic [31:0] b_cmd;
  int b_frises;
  int b_nv, b_rises, b_himin, b_himax, b_lomin, b_lomax, b_csf, b_cspre;
  int b_mbad, b_ibad, b_vdone, b_lastv, b_firstd;
  logic [NB_B*8-1:0] b_bytes;

  sfboot_loader #(.SYS_MHZ(SYS), .SCK_MAX_MHZ(MAX_A), .NBYTES(NB_A), .CSH_CYC(CSH_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .flash_cs_n(a_cs), .flash_sck(a_sck),
    .flash_mosi(a_mosi), .flash_miso(a_miso), .cfg_byte(a_byte), .cfg_valid(a_valid),
    .boot_done(a_done));

  sfboot_loader #(.SYS_MHZ(SYS), .SCK_MAX_MHZ(MAX_B), .NBYTES(NB_B), .CSH_CYC(CSH_B)) u_dut_fast (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .flash_cs_n(b_cs), .flash_sck(b_sck),
    .flash_mosi(b_mosi), .flash_miso(b_miso), .cfg_byte(b_byte), .cfg_valid(b_valid),
    .boot_done(b_done));

  tb_flash_model #(.NB(NB_A)) u_flash_a (.rst_n(rst_n), .cs_n(a_cs), .sck(a_sck), .mosi(a_mosi),
    .seed(seed_a), .miso(a_miso), .cmd(a_cmd), .rises(a_frises));
  tb_flash_model #(.NB(NB_B)) u_flash_b (.rst_n(rst_n), .cs_n(b_cs), .sck(b_sck), .mosi(b_mosi),
    .seed(seed_b), .miso(b_miso), .cmd(b_cmd), .rises(b_frises));

  tb_mon #(.NB(NB_A)) u_mon_a (.clk(clk), .rst_n(rst_n), .cs_n(a_cs), .sck(a_sck), .mosi(a_mosi),
    .valid(a_valid), .data(a_byte), .done(a_done), .n_valid(a_nv), .bytes_flat(a_bytes),
    .sck_rises(a_rises), .hi_min(a_himin), .hi_max(a_himax), .lo_min(a_lomin), .lo_max(a_lomax),
    .cs_falls(a_csf), .cs_pre(a_cspre), .mosi_bad(a_mbad), .idle_bad(a_ibad),
    .valid_in_done(a_vdone), .last_valid_cyc(a_lastv), .first_done_cyc(a_firstd));
  tb_mon #(.NB(NB_B)) u_mon_b (.clk(clk), .rst_n(rst_n), .cs_n(b_cs), .sck(b_sck), .mosi(b_mosi),
    .valid(b_valid), .data(b_byte), .done(b_done), .n_valid(b_nv), .bytes_flat(b_bytes),
    .sck_rises(b_rises), .hi_min(b_himin), .hi_max(b_himax), .lo_min(b_lomin), .lo_max(b_lomax),
    .cs_falls(b_csf), .cs_pre(b_cspre), .mosi_bad(b_mbad), .idle_bad(b_ibad),
    .valid_in_done(b_vdone), .last_valid_cyc(b_lastv), .first_done_cyc(b_firstd));

  function automatic int exp_half(input int sys, input int mx);
    for (int h = 1; h < 1000; h++) if (sys <= 2 * h * mx) return h;
    return 0;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] s, input int i);
    logic [7:0] m;
    m = 8'((i * 29) % 256);
    return s ^ m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [1:0] m);
    @(posedge clk); #2;
    rst_n = 1'b0;
    mode  = m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state of both instances
    chk(a_cs == 1'b1 && b_cs == 1'b1, "R6", "select high in reset", {a_cs, b_cs}, 3);
    chk(a_sck == 1'b0 && b_sck == 1'b0, "R6", "clock low in reset", {a_sck, b_sck}, 0);
    chk(a_done == 1'b0 && b_done == 1'b0 && a_valid == 1'b0 && b_valid == 1'b0,
        "R8", "done and strobe low in reset", {a_done, b_done, a_valid, b_valid}, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!(a_done && b_done) && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_quiet(input string req, input string what);
    chk(a_csf == 0 && b_csf == 0, req, {what, " select falls"}, a_csf + b_csf, 0);
    chk(a_rises == 0 && b_rises == 0, req, {what, " clock edges"}, a_rises + b_rises, 0);
    chk(a_nv == 0 && b_nv == 0, req, {what, " byte strobes"}, a_nv + b_nv, 0);
    chk(a_firstd < 0 && b_firstd < 0, req, {what, " done raised"}, a_firstd + b_firstd, -2);
  endtask

  // Parked boot: straps not serial, later changed to serial (R1, R9)
  task automatic t_parked(input logic [1:0] m);
    apply_reset(m);
    repeat (1200) @(posedge clk);
    @(negedge clk);
    check_quiet("R1", "parked");
    @(posedge clk); #2;
    mode = 2'b10;
    repeat (600) @(posedge clk);
    @(negedge clk);
    check_quiet("R9", "straps changed while parked");
  endtask

  // Serial boot with seeded image; optionally change straps mid-transfer
  task automatic t_boot(input logic [7:0] sa, input logic [7:0] sb, input bit flip);
    int r_a, r_b;
    seed_a = sa;
    seed_b = sb;
    apply_reset(2'b10);
    if (flip) begin
      while (a_cs) @(negedge clk);
      repeat (20) @(posedge clk);
      #2 mode = 2'b01;
    end
    wait_done();
    @(negedge clk);
    // R2 select timing
    chk(a_cspre >= CSH_A, "R2", "A select-high guard", a_cspre, CSH_A);
    chk(b_cspre >= CSH_B, "R2", "B select-high guard", b_cspre, CSH_B);
    chk(a_csf == 1 && b_csf == 1, "R2", "single select assertion", a_csf + b_csf, 2);
    // R3 header
    chk(a_cmd == 32'h0300_0000, "R3", "A read header", a_cmd, 32'h0300_0000);
    chk(b_cmd == 32'h0300_0000, "R3", "B read header", b_cmd, 32'h0300_0000);
    // R4 outbound stability
    chk(a_mbad == 0 && b_mbad == 0, "R4", "mosi changes while clock high", a_mbad + b_mbad, 0);
    // R5 bytes
    chk(a_nv == NB_A, "R5", "A byte count", a_nv, NB_A);
    chk(b_nv == NB_B, "R5", "B byte count", b_nv, NB_B);
    for (int i = 0; i < NB_A; i++)
      chk(a_bytes[i*8 +: 8] == exp_byte(sa, i), "R5", $sformatf("A byte %0d", i),
          a_bytes[i*8 +: 8], exp_byte(sa, i));
    for (int i = 0; i < NB_B; i++)
      chk(b_bytes[i*8 +: 8] == exp_byte(sb, i), "R5", $sformatf("B byte %0d", i),
          b_bytes[i*8 +: 8], exp_byte(sb, i));
    // R6 edge counts and idle level
    chk(a_rises == 32 + 8 * NB_A, "R6", "A clock edges", a_rises, 32 + 8 * NB_A);
    chk(b_rises == 32 + 8 * NB_B, "R6", "B clock edges", b_rises, 32 + 8 * NB_B);
    chk(a_ibad == 0 && b_ibad == 0, "R6", "clock high while deselected", a_ibad + b_ibad, 0);
    // R7 phase lengths
    chk(a_himin == exp_half(SYS, MAX_A) && a_himax == exp_half(SYS, MAX_A), "R7",
        "A high phase", a_himax, exp_half(SYS, MAX_A));
    chk(a_lomin == exp_half(SYS, MAX_A) && a_lomax == exp_half(SYS, MAX_A), "R7",
        "A low phase", a_lomax, exp_half(SYS, MAX_A));
    chk(b_himin == exp_half(SYS, MAX_B) && b_himax == exp_half(SYS, MAX_B), "R7",
        "B high phase", b_himax, exp_half(SYS, MAX_B));
    chk(b_lomin == exp_half(SYS, MAX_B) && b_lomax == exp_half(SYS, MAX_B), "R7",
        "B low phase", b_lomax, exp_half(SYS, MAX_B));
    // R10 ordering of last strobe and done
    chk(a_lastv < a_firstd, "R10", "A last strobe before done", a_lastv, a_firstd);
    chk(b_lastv < b_firstd, "R10", "B last strobe before done", b_lastv, b_firstd);
    // R8 hold after completion
    r_a = a_rises;
    r_b = b_rises;
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(a_done && b_done, "R8", "done held", {a_done, b_done}, 3);
    chk(a_cs && b_cs, "R8", "select held high", {a_cs, b_cs}, 3);
    chk(a_rises == r_a && b_rises == r_b, "R8", "no clock after done",
        a_rises + b_rises, r_a + r_b);
    chk(a_vdone == 0 && b_vdone == 0 && a_nv == NB_A && b_nv == NB_B, "R10",
        "no strobe while done", a_vdone + b_vdone, 0);
    if (flip)
      chk(a_nv == NB_A && a_done, "R9", "transfer survives strap change", a_nv, NB_A);
  endtask

  initial begin
    #(1_500_000);
    errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_parked(2'b00);
    t_parked(2'b11);
    t_boot(8'h5A, 8'hC3, 1'b0);
    t_boot(8'h0F, 8'hFF, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule